// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for a synchronous memory that serves accesses in bursts of four beats. An external base address is captured when either of two active-low address strobes is low and the qualified load enable from the surrounding select logic is high. Later beats come from an internal two-bit beat index, moved forward by an active-low advance input. Only the two lowest address bits change within a burst, and the burst wraps inside its aligned group of four. The upper bits keep the captured value.

Two orderings exist. In linear order the low bits are the captured low bits plus the beat index, modulo four. In interleaved order they are the captured low bits XOR the beat index. The order input is latched together with the base address. The reset value of the latch is interleaved. A suspend input, or the advance input held high, freezes the current address.

A small state machine tracks the burst. It has three states. ST_IDLE is entered from reset and means no base has been loaded yet. ST_RUN means the last cycle loaded or advanced. ST_PAUSE means the last cycle held. Transitions:
- A load moves any state to ST_RUN.
- ST_IDLE stays in ST_IDLE when no load occurs.
- ST_RUN stays in ST_RUN on an advance and goes to ST_PAUSE on a hold.
- ST_PAUSE goes to ST_RUN on an advance and stays in ST_PAUSE on a hold.

Top module: `burst_addr_gen`

## Requirements
- R1: When ads_p_n or ads_c_n is 0 and load_en is 1 at a rising edge, cur_addr equals ext_addr from the next cycle on.
- R2: When load_en is 0, a low strobe has no effect: the cycle behaves as an advance or a hold according to adv_n and hold.
- R3: When no load occurs and either adv_n is 1 or hold is 1, cur_addr keeps its value.
- R4: A load takes priority over an advance in the same cycle.
- R5: When no load occurs, bits [AW-1:2] of cur_addr never change.
- R6: With the latched order at 0 (linear), each advance sets cur_addr[1:0] to the previous value plus 1, modulo 4. For example, start 2 gives 2,3,0,1.
- R7: With the latched order at 1 (interleaved), the n-th beat's cur_addr[1:0] equals the start low bits XOR n. For example, start 1 gives 1,0,3,2.
- R8: The fourth advance after a load returns cur_addr to the loaded address.
- R9: order_ilv is latched only at a load. Changing it during a burst does not alter the ordering.
- R10: After reset and before the first load, advances are ignored and cur_addr stays 0.
- R11: A synchronous reset (rst high at an edge) sets cur_addr to 0, clears the beat index and returns the block to ST_IDLE.
- R12: A load during a burst restarts the sequence at beat 0 from the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | AW | External base address |
| ads_p_n | input | 1 | Address strobe A, active low |
| ads_c_n | input | 1 | Address strobe B, active low |
| load_en | input | 1 | Qualified enable for the strobes |
| adv_n | input | 1 | Burst advance, active low |
| hold | input | 1 | Suspend: blocks advance when high |
| order_ilv | input | 1 | Ordering: 1 interleaved, 0 linear |
| cur_addr | output | AW | Current internal address |

## Verification
Two situations are hard to reach from the ports. The first is a change of the order input in the middle of a burst, because a design that reads order_ilv live behaves like a correct one until that input moves between a load and an advance. The bench loads in linear order from start 1, raises order_ilv, and advances; the linear result 2 differs from the interleaved result 0. The second is a strobe with load_en low during an active burst. The bench drives that together with an advance, so a wrongly accepted load would show as the ignored ext_addr rather than the next beat.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2
    } burst_state_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int LB = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [LB-1:0] beat
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            beat <= '0;
        end else if (inc) begin
            beat <= beat + 1'b1;
        end
    end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
    parameter int LB = 2
) (
    input  logic [LB-1:0] base_lo,
    input  logic [LB-1:0] beat,
    input  logic          ilv,
    output logic [LB-1:0] lo
);
    logic [LB-1:0] lin_lo;
    logic [LB-1:0] xor_lo;

    assign lin_lo = base_lo + beat;

    for (genvar b = 0; b < LB; b++) begin : g_xor
        assign xor_lo[b] = base_lo[b] ^ beat[b];
    end

    assign lo = ilv ? xor_lo : lin_lo;
endmodule

// File: rtl/burst_ctrl_fsm.sv
module burst_ctrl_fsm
    import burst_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    output burst_state_e state_q,
    output logic         beat_clr,
    output logic         beat_inc
);
    burst_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_RUN:   state_d = step ? ST_RUN : ST_PAUSE;
                ST_PAUSE: state_d = step ? ST_RUN : ST_PAUSE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        beat_clr = load;
        beat_inc = !load && step && (state_q != ST_IDLE);
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int AW = 17,
    parameter int LB = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ext_addr,
    input  logic          ads_p_n,
    input  logic          ads_c_n,
    input  logic          load_en,
    input  logic          adv_n,
    input  logic          hold,
    input  logic          order_ilv,
    output logic [AW-1:0] cur_addr
);
    localparam int HW = AW - LB;

    logic          load;
    logic          step;
    logic [AW-1:0] base_q;
    logic          mode_q;
    logic [LB-1:0] beat;
    logic [LB-1:0] lo;
    logic          beat_clr;
    logic          beat_inc;
    burst_state_e  state_q;

    assign load = load_en && (!ads_p_n || !ads_c_n);
    assign step = !adv_n && !hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            mode_q <= 1'b1;
        end else if (load) begin
            base_q <= ext_addr;
            mode_q <= order_ilv;
        end
    end

    burst_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .state_q  (state_q),
        .beat_clr (beat_clr),
        .beat_inc (beat_inc)
    );

    burst_beat_ctr #(.LB(LB)) u_beat (
        .clk  (clk),
        .rst  (rst),
        .clr  (beat_clr),
        .inc  (beat_inc),
        .beat (beat)
    );

    burst_order_map #(.LB(LB)) u_map (
        .base_lo (base_q[LB-1:0]),
        .beat    (beat),
        .ilv     (mode_q),
        .lo      (lo)
    );

    assign cur_addr = {base_q[AW-1:AW-HW], lo};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk
    import burst_pkg::*;
#(
    parameter int AW = 17,
    parameter int LB = 2
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] ext_addr,
    input logic          ads_p_n,
    input logic          ads_c_n,
    input logic          load_en,
    input logic          adv_n,
    input logic          hold,
    input logic [AW-1:0] cur_addr,
    input burst_state_e  state_q,
    input logic          mode_q,
    input logic [LB-1:0] base_lo
);
    logic          ld;
    logic          stp;
    logic [LB-1:0] cur_lo;
    logic [LB-1:0] lo_plus;
    logic [LB-1:0] cur_idx;
    logic [LB-1:0] idx_plus;

    assign ld       = load_en && (!ads_p_n || !ads_c_n);
    assign stp      = !adv_n && !hold;
    assign cur_lo   = cur_addr[LB-1:0];
    assign lo_plus  = cur_lo + 1'b1;
    assign cur_idx  = cur_lo ^ base_lo;
    assign idx_plus = cur_idx + 1'b1;

    AST_LOAD_TAKES_EXT: assert property (@(posedge clk) disable iff (rst)
        ld |=> cur_addr == $past(ext_addr));                             // R1
    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (!ld && !stp) |=> $stable(cur_addr));                            // R3
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(cur_addr[AW-1:LB]));                             // R5
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!ld && stp && state_q != ST_IDLE && !mode_q)
        |=> cur_lo == $past(lo_plus));                                   // R6
    AST_XOR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!ld && stp && state_q != ST_IDLE && mode_q)
        |=> cur_idx == $past(idx_plus));                                 // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !ld) |=> cur_addr == '0);                // R10
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cur_addr == '0 && state_q == ST_IDLE));                 // R11
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW), .LB(LB)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .ext_addr (ext_addr),
    .ads_p_n  (ads_p_n),
    .ads_c_n  (ads_c_n),
    .load_en  (load_en),
    .adv_n    (adv_n),
    .hold     (hold),
    .cur_addr (cur_addr),
    .state_q  (state_q),
    .mode_q   (mode_q),
    .base_lo  (base_q[LB-1:0])
);

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
    localparam int CLK_P = 10;
    localparam int AW    = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          ads_p_n = 1'b1;
    logic          ads_c_n = 1'b1;
    logic          load_en = 1'b0;
    logic          adv_n = 1'b1;
    logic          hold = 1'b0;
    logic          order_ilv = 1'b1;
    logic [AW-1:0] cur_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    burst_addr_gen #(.AW(AW), .LB(2)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .ext_addr  (ext_addr),
        .ads_p_n   (ads_p_n),
        .ads_c_n   (ads_c_n),
        .load_en   (load_en),
        .adv_n     (adv_n),
        .hold      (hold),
        .order_ilv (order_ilv),
        .cur_addr  (cur_addr)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input bit ilv, input int n);
        logic [1:0] s;
        logic [1:0] k;
        s = b[1:0];
        k = 2'(n);
        return {b[AW-1:2], ilv ? (s ^ k) : (s + k)};
    endfunction

    task automatic load(input logic [AW-1:0] a, input bit ilv, input bit use_c);
        ext_addr = a; order_ilv = ilv; load_en = 1'b1;
        if (use_c) ads_c_n = 1'b0; else ads_p_n = 1'b0;
        tick();
        ads_p_n = 1'b1; ads_c_n = 1'b1; load_en = 1'b0;
        ext_addr = ~a;
    endtask

    task automatic adv();
        adv_n = 1'b0; tick(); adv_n = 1'b1;
    endtask

    task automatic t_reset_idle();
        rst = 1'b1; tick(); tick(); rst = 1'b0;
        chk("R11 reset address", cur_addr, '0);
        adv(); adv();
        chk("R10 advance before load", cur_addr, '0);
    endtask

    task automatic t_linear();
        logic [AW-1:0] b = 17'h1ABCE;
        load(b, 1'b0, 1'b0);
        chk("R1 load via strobe A", cur_addr, b);
        for (int n = 1; n < 4; n++) begin
            adv();
            chk("R6 linear beat", cur_addr, beat_addr(b, 1'b0, n));
            chk("R5 upper bits", {cur_addr[AW-1:2], 2'b00}, {b[AW-1:2], 2'b00});
        end
        adv();
        chk("R8 wrap to start", cur_addr, b);
    endtask

    task automatic t_interleaved();
        logic [AW-1:0] b1 = 17'h0F0F1;
        logic [AW-1:0] b2 = 17'h12346;
        load(b1, 1'b1, 1'b1);
        chk("R1 load via strobe B", cur_addr, b1);
        for (int n = 1; n < 4; n++) begin
            adv();
            chk("R7 interleaved beat start 1", cur_addr, beat_addr(b1, 1'b1, n));
        end
        adv();
        chk("R8 interleaved wrap", cur_addr, b1);
        load(b2, 1'b1, 1'b0);
        for (int n = 1; n < 4; n++) begin
            adv();
            chk("R7 interleaved beat start 2", cur_addr, beat_addr(b2, 1'b1, n));
        end
    endtask

    task automatic t_suspend();
        logic [AW-1:0] b = 17'h00A40;
        load(b, 1'b0, 1'b0);
        adv();
        tick(); tick();
        chk("R3 hold with advance high", cur_addr, beat_addr(b, 1'b0, 1));
        hold = 1'b1; adv(); adv(); hold = 1'b0;
        chk("R3 hold input blocks advance", cur_addr, beat_addr(b, 1'b0, 1));
        adv();
        chk("R3 resumes after hold", cur_addr, beat_addr(b, 1'b0, 2));
    endtask

    task automatic t_mode_latched();
        logic [AW-1:0] b = 17'h05551;
        load(b, 1'b0, 1'b0);
        order_ilv = 1'b1;
        adv();
        chk("R9 order change mid burst ignored", cur_addr, beat_addr(b, 1'b0, 1));
    endtask

    task automatic t_unqualified();
        logic [AW-1:0] b = 17'h1C000;
        load(b, 1'b1, 1'b0);
        ext_addr = 17'h0777B; ads_p_n = 1'b0; ads_c_n = 1'b0; load_en = 1'b0;
        adv();
        ads_p_n = 1'b1; ads_c_n = 1'b1;
        chk("R2 strobe without enable ignored", cur_addr, beat_addr(b, 1'b1, 1));
    endtask

    task automatic t_restart();
        logic [AW-1:0] b  = 17'h02202;
        logic [AW-1:0] b2 = 17'h13333;
        load(b, 1'b0, 1'b0);
        adv(); adv();
        ext_addr = b2; order_ilv = 1'b0; load_en = 1'b1; ads_c_n = 1'b0; adv_n = 1'b0;
        tick();
        ads_c_n = 1'b1; load_en = 1'b0; adv_n = 1'b1;
        chk("R4 load wins over advance", cur_addr, b2);
        adv();
        chk("R12 restart from new base beat 1", cur_addr, beat_addr(b2, 1'b0, 1));
        rst = 1'b1; tick(); rst = 1'b0;
        chk("R11 reset mid burst", cur_addr, '0);
        adv();
        chk("R10 advance after reset ignored", cur_addr, '0);
    endtask

    initial begin
        #1;
        t_reset_idle();
        t_linear();
        t_interleaved();
        t_suspend();
        t_mode_latched();
        t_unqualified();
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule